// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter whose state bits all change together on the rising clock edge. It can be preset from a parallel data input. It can be cleared either at once or on the next edge. It advances only when two separate count enables are both high. A terminal-count carry output is gated by only one of the two enables, the "T" enable. This lets several copies be chained into one wider synchronous counter with no extra logic: the carry of one stage drives the enables of the next stage, and all stages share a single clock.

A build-time parameter chooses how the clear behaves. With `CLEAR_ASYNC = 0` the clear acts on the next rising edge. In that mode a decode of any chosen count can drive the clear, which shortens the counting cycle. With `CLEAR_ASYNC = 1` the clear zeroes the state as soon as it goes low, with no clock needed. None of the pins carries a data stream, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level-sensitive control or status signal.

On a clock edge the priority is fixed: clear first, then load, then count, then hold.

Top module: `presettable_counter`

## Requirements
- R1: With `CLEAR_ASYNC = 0`, `clr_n` low at a rising edge makes `q` zero after that edge, whatever `load_n`, `en_p` and `en_t` are.
- R2: With `CLEAR_ASYNC = 1`, `q` becomes zero as soon as `clr_n` goes low, without a clock edge, and it stays zero while `clr_n` is low.
- R3: With `clr_n` high and `load_n` low at a rising edge, `q` takes the value of `din` after that edge, whatever the enables are.
- R4: With `clr_n` and `load_n` high and both `en_p` and `en_t` high at a rising edge, `q` increments by one. It wraps from all ones (15 at the default width) to zero.
- R5: With `clr_n` and `load_n` high and either enable low at a rising edge, `q` keeps its value.
- R6: `carry_out` is high exactly when `en_t` is high and `q` is all ones. It follows these inputs in the same cycle, and `en_p` has no effect on it.
- R7: Changes on `load_n`, `en_p`, `en_t` or `din` between rising edges leave `q` unchanged until the next rising edge.
- R8: Two stages chained, with the low stage's `carry_out` driving both enables of the high stage, count as one 8-bit synchronous counter that wraps from 255 to 0. The high stage's `carry_out` is high at 255 while counting is enabled.
- R9: With `CLEAR_ASYNC = 0` and `clr_n` driven low by a decode of `q == 9`, the counter cycles through 0 to 9 and returns to 0 on the edge after it reaches 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all state bits |
| clr_n | input | 1 | Active-low clear. It acts on the next edge or at once, as `CLEAR_ASYNC` selects |
| load_n | input | 1 | Active-low parallel preset |
| en_p | input | 1 | Count enable that gates counting only |
| en_t | input | 1 | Count enable that also gates `carry_out` |
| din | input | WIDTH | Parallel preset value |
| q | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal-count carry, used to chain stages |

## Verification
The bench aims at the priority corners of the control inputs. A clear asserted together with a load must win, or the counter would preset instead of zeroing. A load with both enables low must still take effect, or a preset would wrongly depend on the enables. The carry is checked with `en_p` low and `en_t` high at all ones; a design that gated the carry with the wrong enable would drop the carry there and stall a chained stage. Mid-cycle toggles, an asynchronous clear pulse between edges, the 255-to-0 wrap of a two-stage chain and the 9-to-0 return of a truncated count each catch a design that samples at the wrong time, misses a wrap or clears one cycle late.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } pcnt_op_e;
endpackage

// File: rtl/pcnt_ctrl.sv
// Picks the single operation for the coming edge: clear, then load, then count, then hold.
module pcnt_ctrl #(
  parameter bit CLEAR_ASYNC = 1'b0
) (
  input  logic               clr_n,
  input  logic               load_n,
  input  logic               en_p,
  input  logic               en_t,
  output pcnt_pkg::pcnt_op_e op
);
  import pcnt_pkg::*;

  logic sync_clear;

  generate
    if (CLEAR_ASYNC) begin : g_clr_async
      // the state register applies the clear itself, without the clock
      assign sync_clear = 1'b0;
    end else begin : g_clr_sync
      assign sync_clear = ~clr_n;
    end
  endgenerate

  always_comb begin
    if (sync_clear)          op = OP_CLEAR;
    else if (!load_n)        op = OP_LOAD;
    else if (en_p && en_t)   op = OP_COUNT;
    else                     op = OP_HOLD;
  end
endmodule

// File: rtl/pcnt_state.sv
// Count register. Every bit is loaded in the same edge; the clear style is chosen by generate.
module pcnt_state #(
  parameter int unsigned WIDTH       = 4,
  parameter bit          CLEAR_ASYNC = 1'b0
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               load_n,
  input  logic               en_p,
  input  logic               en_t,
  input  pcnt_pkg::pcnt_op_e op,
  input  logic [WIDTH-1:0]   din,
  output logic [WIDTH-1:0]   q
);
  import pcnt_pkg::*;

  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  logic [WIDTH-1:0] nxt;

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = ZERO;
      OP_LOAD:  nxt = din;
      OP_COUNT: nxt = q + STEP;
      default:  nxt = q;
    endcase
  end

  generate
    if (CLEAR_ASYNC) begin : g_reg_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= ZERO;
        else        q <= nxt;
      end

      AST_CLEAR_IMMEDIATE: assert property (@(posedge clk)
        !clr_n |-> q == ZERO); // R2
    end else begin : g_reg_sync
      always_ff @(posedge clk) begin
        q <= nxt;
      end

      AST_CLEAR_NEXT_EDGE: assert property (@(posedge clk)
        !clr_n |=> q == ZERO); // R1
    end
  endgenerate

  AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din)); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t) |=> q == WIDTH'($past(q) + STEP)); // R4

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(q)); // R5
endmodule

// File: rtl/pcnt_carry.sv
// Terminal-count carry: all ones on the state, qualified by the T enable only.
module pcnt_carry #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_t,
  output logic             carry
);
  logic at_top;

  assign at_top = &q;
  assign carry  = at_top & en_t;
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter #(
  parameter int unsigned WIDTH       = 4,
  parameter bit          CLEAR_ASYNC = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);
  import pcnt_pkg::*;

  pcnt_op_e op;

  pcnt_ctrl #(.CLEAR_ASYNC(CLEAR_ASYNC)) ctrl_i (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .op     (op)
  );

  pcnt_state #(.WIDTH(WIDTH), .CLEAR_ASYNC(CLEAR_ASYNC)) state_i (
    .clk    (clk),
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .op     (op),
    .din    (din),
    .q      (q)
  );

  pcnt_carry #(.WIDTH(WIDTH)) carry_i (
    .q      (q),
    .en_t   (en_t),
    .carry  (carry_out)
  );

  // a carry seen while counting must be followed by the wrap to zero
  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (!clr_n)
    (carry_out && en_p && load_n) |=> q == '0); // R6
endmodule

// File: tb/presettable_counter_tb_top.sv
`timescale 1ns/1ps
module presettable_counter_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       clr_s_n = 1'b0, clr_a_n = 1'b0, clr_c_n = 1'b0, clr_m_n = 1'b0;
  logic       load_n = 1'b1, en_p = 1'b0, en_t = 1'b0, c_en = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] q_s, q_a, q_lo, q_hi, q_m;
  logic       co_s, co_a, co_lo, co_hi, co_m, clr_m_eff;

  int checks = 0;
  int errors = 0;
  int ms = -1, ma = -1, mc = -1, mm = -1;
  string ts = "R1", ta = "R2";

  presettable_counter #(.WIDTH(4), .CLEAR_ASYNC(1'b0)) dut_i (
    .clk(clk), .clr_n(clr_s_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(q_s), .carry_out(co_s));

  presettable_counter #(.WIDTH(4), .CLEAR_ASYNC(1'b1)) dut_async_i (
    .clk(clk), .clr_n(clr_a_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(q_a), .carry_out(co_a));

  presettable_counter #(.WIDTH(4), .CLEAR_ASYNC(1'b0)) stage_lo_i (
    .clk(clk), .clr_n(clr_c_n), .load_n(1'b1), .en_p(c_en), .en_t(c_en),
    .din(4'd0), .q(q_lo), .carry_out(co_lo));

  presettable_counter #(.WIDTH(4), .CLEAR_ASYNC(1'b0)) stage_hi_i (
    .clk(clk), .clr_n(clr_c_n), .load_n(1'b1), .en_p(co_lo), .en_t(co_lo),
    .din(4'd0), .q(q_hi), .carry_out(co_hi));

  assign clr_m_eff = clr_m_n & ~(q_m == 4'd9);
  presettable_counter #(.WIDTH(4), .CLEAR_ASYNC(1'b0)) dut_mod_i (
    .clk(clk), .clr_n(clr_m_eff), .load_n(1'b1), .en_p(1'b1), .en_t(1'b1),
    .din(4'd0), .q(q_m), .carry_out(co_m));

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!clr_s_n) begin ms = 0; ts = "R1"; end
    else if (!load_n) begin ms = din; ts = "R3"; end
    else if (en_p && en_t) begin if (ms >= 0) ms = (ms + 1) % 16; ts = "R4"; end
    else ts = "R5";

    if (!clr_a_n) begin ma = 0; ta = "R2"; end
    else if (!load_n) begin ma = din; ta = "R3"; end
    else if (en_p && en_t) begin if (ma >= 0) ma = (ma + 1) % 16; ta = "R4"; end
    else ta = "R5";

    if (!clr_c_n) mc = 0;
    else if (c_en && mc >= 0) mc = (mc + 1) % 256;

    if (!clr_m_n) mm = 0;
    else if (mm >= 0) mm = (mm == 9) ? 0 : mm + 1;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    if (ms >= 0) begin
      chk(ts, 32'(q_s), 32'(ms));
      chk("R6 sync carry", 32'(co_s), 32'(en_t && ms == 15));
    end
    if (ma >= 0) begin
      chk(ta, 32'(q_a), 32'(ma));
      chk("R6 async carry", 32'(co_a), 32'(en_t && ma == 15));
    end
    if (mc >= 0) begin
      chk("R8 chained count", 32'({q_hi, q_lo}), 32'(mc));
      chk("R8 chained carry", 32'(co_hi), 32'(c_en && mc == 255));
    end
    if (mm >= 0) chk("R9 truncated count", 32'(q_m), 32'(mm));
  endtask

  task automatic step(logic cs, logic ca, logic ld, logic p, logic t, logic [3:0] d);
    @(negedge clk);
    compare_all();
    clr_s_n = cs; clr_a_n = ca; load_n = ld; en_p = p; en_t = t; din = d;
  endtask

  // R7: toggle the controls between edges; the state must not move
  task automatic glitch_between_edges();
    logic [3:0] keep_s, keep_a;
    logic ld0, p0, t0;
    logic [3:0] d0;
    @(posedge clk);
    #1;
    keep_s = q_s; keep_a = q_a;
    ld0 = load_n; p0 = en_p; t0 = en_t; d0 = din;
    load_n = 1'b0; din = ~q_s; en_p = ~en_p; en_t = 1'b1;
    #1;
    chk("R7 sync", 32'(q_s), 32'(keep_s));
    chk("R7 async", 32'(q_a), 32'(keep_a));
    load_n = ld0; en_p = p0; en_t = t0; din = d0;
  endtask

  bit done = 1'b0;
  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(0, 0, 0, 1, 1, 4'd7);          // R1: clear beats load at reset
    step(0, 0, 1, 1, 1, 4'd0);
    clr_c_n = 1'b1; clr_m_n = 1'b1;
    step(1, 1, 0, 0, 0, 4'hE);          // R3: load with enables low
    step(1, 1, 1, 1, 0, 4'h0);          // R5: only P
    step(1, 1, 1, 0, 1, 4'h0);          // R5: only T, carry low at 14
    step(1, 1, 1, 1, 1, 4'h0);          // R4 -> 15
    step(1, 1, 1, 0, 1, 4'h0);          // R6: carry with P low at 15
    step(1, 1, 1, 0, 0, 4'h0);          // R6: carry low with T low
    step(1, 1, 1, 1, 1, 4'h0);          // R4: wrap to 0
    step(1, 1, 0, 1, 1, 4'h9);
    step(0, 1, 0, 1, 1, 4'h5);          // R1: clear beats load
    step(1, 1, 1, 1, 1, 4'h0);
    glitch_between_edges();
    step(1, 1, 1, 0, 0, 4'h0);
    glitch_between_edges();
    step(1, 1, 0, 1, 1, 4'hC);
    // R2: asynchronous clear pulse between edges
    @(posedge clk);
    #1 clr_a_n = 1'b0;
    #1 chk("R2 clear without edge", 32'(q_a), 32'd0);
    ma = 0; ta = "R2";
    step(1, 0, 1, 1, 1, 4'h0);
    step(1, 1, 1, 1, 1, 4'h0);
    c_en = 1'b1;
    for (int i = 0; i < 600; i++) begin
      logic cs, ld, p, t;
      cs = ($urandom % 16) != 0;
      ld = ($urandom % 8) != 0;
      p  = ($urandom % 4) != 0;
      t  = ($urandom % 4) != 0;
      c_en = ($urandom % 8) != 0;
      step(cs, (($urandom % 16) != 0), ld, p, t, 4'($urandom));
    end
    c_en = 1'b1;
    for (int i = 0; i < 300; i++) step(1, 1, 1, 1, 1, 4'h0);
    step(1, 1, 1, 1, 1, 4'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule